// File: doc/BRIEF.md
# Pipelined Vectoring Envelope and Phase Detector

This block turns a stream of complex baseband samples into an amplitude-demodulated audio stream. Each accepted I/Q pair is folded into the right half-plane, then pushed through a chain of shift-add rotation stages. Each stage nudges the vector toward the positive x axis and records the elementary angle it turned through. When the chain ends, the x register holds the vector length times the known rotation gain, and the angle register holds the phase of the input.

The length is multiplied by a constant built from shifted copies to cancel the rotation gain, then clipped into the positive half of a 16-bit signed range. This gives the envelope. A one-pole high-pass filter then subtracts the slowly varying mean of the envelope, so that the carrier level does not appear as an offset on the audio. The phase word comes out beside the envelope. A new sample can enter on every clock, and results appear a fixed 18 cycles later with their own valid strobe.

Top module: `envelopeVectorDetector`

## Requirements
- R1: When `validIn` is high at a rising clock edge, that sample is accepted, with no stall ever. `validOut` goes high exactly 18 rising edges later for one cycle per accepted sample and is low otherwise, including during the first 17 edges after reset.
- R2: While `rstN` is low, `validOut`, `envOut`, `audioOut` and `angleOut` are all zero.
- R3: A sample with negative I is first negated in both I and Q, and its angle register starts at 32768 (half a turn). Any other sample starts its angle register at 0.
- R4: There are 16 rotation steps k = 0..15 on 18-bit signed x/y. The sign rule is applied to y before each step. If y < 0: x -= y>>>k, y += x>>>k, angle -= T[k]. Otherwise: x += y>>>k, y -= x>>>k, angle += T[k]. Here >>> is an arithmetic right shift that truncates toward minus infinity. T = {8192,4836,2555,1297,651,326,163,81,41,20,10,5,3,1,1,0}, i.e. round(atan(2^-k)·32768/π).
- R5: `angleOut` is the final angle register modulo 65536, with 65536 counts per full turn (two's complement reading gives ±half a turn).
- R6: `envOut` = min(32767, floor(x·311/512)), where x is the x register after the last step. 311/512 ≈ 0.6074 cancels the ≈1.647 rotation gain.
- R7: An input with I = 0 and Q = 0 yields `envOut` = 0 and `angleOut` = 0.
- R8: A filter state A starts at 0 on reset. With each valid output, `audioOut` = `envOut` − (A>>>6), and then A becomes A + `audioOut`. A does not change in any cycle without a valid output.
- R9: `envOut` is never negative, and `audioOut` stays within −32767..32767 (never 0x8000) whenever `validOut` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Marks `iIn`/`qIn` as a sample to accept |
| iIn | input | 16 | In-phase component, signed two's complement |
| qIn | input | 16 | Quadrature component, signed two's complement |
| validOut | output | 1 | Marks the output words as a result |
| envOut | output | 16 | Gain-corrected envelope, signed, 0..32767 |
| audioOut | output | 16 | Envelope with its running mean removed, signed |
| angleOut | output | 16 | Input phase, 65536 counts per turn |

## Verification
Two functions can act on the same result in one cycle: clipping of the gain-corrected envelope, and the update of the DC-removal state. A clipped value is the one fed into the accumulator, so an error in either shows up in every later audio sample. This is provoked by sending full-scale corner vectors back to back, between tone and random traffic. In the same streams, zero vectors and negative-I vectors sit right next to each other, so a forced zero angle and a half-turn pre-rotation leave the pipeline on consecutive cycles. A behavioural model with its own accumulator, using integer arithmetic, judges every output cycle. A single wrong clip or stale accumulator value therefore also makes the following audio samples mismatch.

// File: rtl/envDetPkg.sv
package envDetPkg;

  // Angle words: 65536 counts per full turn.
  localparam int ANG_W = 16;

  // Gain correction constant: GAIN_NUM / 2^GAIN_SHIFT ~ 1/1.647
  localparam int GAIN_NUM   = 311;
  localparam int GAIN_SHIFT = 9;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic commit;   // the final rotation stage holds a real sample
  } ctrlStrb_t;

  // Elementary rotation angles atan(2^-k) in ANG_W-bit turn units.
  function automatic int atanStep(input int k);
    case (k)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      14: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/envDetCtrl.sv
module envDetCtrl
  import envDetPkg::*;
#(
  parameter int LAT = 18
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      validIn,
  output ctrlStrb_t strb,
  output logic      validOut
);

  localparam int CW = $clog2(LAT + 1);

  logic [LAT-1:0] vPipe;
  logic [CW-1:0]  sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
    end else begin
      vPipe <= {vPipe[LAT-2:0], validIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst != CW'(LAT)) begin
      sinceRst <= sinceRst + 1'b1;
    end
  end

  assign strb.commit = vPipe[LAT-2];
  assign validOut    = vPipe[LAT-1];

  // R1: nothing can leave the pipeline before LAT edges have passed
  a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < CW'(LAT)) |-> !validOut);

endmodule

// File: rtl/envDetDatapath.sv
module envDetDatapath
  import envDetPkg::*;
#(
  parameter int IN_W     = 16,
  parameter int XY_W     = 18,
  parameter int ITER     = 16,
  parameter int OUT_W    = 16,
  parameter int HP_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  iIn,
  input  logic [IN_W-1:0]  qIn,
  input  ctrlStrb_t        strb,
  output logic [OUT_W-1:0] envOut,
  output logic [OUT_W-1:0] audioOut,
  output logic [ANG_W-1:0] angleOut
);

  localparam int PROD_W = XY_W + GAIN_SHIFT + 1;
  localparam int ACC_W  = OUT_W + HP_SHIFT + 2;
  localparam logic [ANG_W-1:0] HALF_TURN = ANG_W'(1) << (ANG_W - 1);
  localparam int ENV_MAX = (1 << (OUT_W - 1)) - 1;

  // ---------------- quadrant fold ----------------
  logic signed [XY_W-1:0]  foldX, foldY;
  logic [ANG_W-1:0]        foldZ;
  logic                    foldZero;
  logic signed [XY_W-1:0]  iExt, qExt;

  assign iExt = XY_W'($signed(iIn));
  assign qExt = XY_W'($signed(qIn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foldX    <= '0;
      foldY    <= '0;
      foldZ    <= '0;
      foldZero <= 1'b0;
    end else begin
      foldZero <= (iIn == '0) && (qIn == '0);
      if (iIn[IN_W-1]) begin
        foldX <= -iExt;
        foldY <= -qExt;
        foldZ <= HALF_TURN;
      end else begin
        foldX <= iExt;
        foldY <= qExt;
        foldZ <= '0;
      end
    end
  end

  // ---------------- rotation stages ----------------
  for (genvar k = 0; k < ITER; k++) begin : stg
    localparam logic [ANG_W-1:0] STEP = ANG_W'(atanStep(k));

    logic signed [XY_W-1:0] x, y;
    logic [ANG_W-1:0]       z;
    logic                   zf;
    logic signed [XY_W-1:0] xPrev, yPrev;
    logic [ANG_W-1:0]       zPrev;
    logic                   zfPrev;

    if (k == 0) begin : src
      assign xPrev  = foldX;
      assign yPrev  = foldY;
      assign zPrev  = foldZ;
      assign zfPrev = foldZero;
    end else begin : src
      assign xPrev  = stg[k-1].x;
      assign yPrev  = stg[k-1].y;
      assign zPrev  = stg[k-1].z;
      assign zfPrev = stg[k-1].zf;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        x  <= '0;
        y  <= '0;
        z  <= '0;
        zf <= 1'b0;
      end else begin
        zf <= zfPrev;
        if (yPrev[XY_W-1]) begin
          x <= xPrev - (yPrev >>> k);
          y <= yPrev + (xPrev >>> k);
          z <= zPrev - STEP;
        end else begin
          x <= xPrev + (yPrev >>> k);
          y <= yPrev - (xPrev >>> k);
          z <= zPrev + STEP;
        end
      end
    end
  end

  logic signed [XY_W-1:0] xFin, yFin;
  logic [ANG_W-1:0]       zFin;
  logic                   zfFin;

  assign xFin  = stg[ITER-1].x;
  assign yFin  = stg[ITER-1].y;
  assign zFin  = stg[ITER-1].z;
  assign zfFin = stg[ITER-1].zf;

  // ---------------- gain correction ----------------
  logic [PROD_W-1:0] xMag, prod, scaled;
  logic [OUT_W-1:0]  envNext;

  assign xMag = PROD_W'(xFin);

  always_comb begin
    prod = '0;
    for (int b = 0; b <= GAIN_SHIFT; b++) begin
      if (GAIN_NUM[b]) prod = prod + (xMag << b);
    end
    scaled = prod >> GAIN_SHIFT;
    if (xFin[XY_W-1]) begin
      envNext = '0;
    end else if (scaled > PROD_W'(ENV_MAX)) begin
      envNext = OUT_W'(ENV_MAX);
    end else begin
      envNext = scaled[OUT_W-1:0];
    end
  end

  // ---------------- DC removal ----------------
  logic signed [ACC_W-1:0] dcAcc, dcEst, envExt, audioWide;

  assign dcEst     = dcAcc >>> HP_SHIFT;
  assign envExt    = ACC_W'(envNext);
  assign audioWide = envExt - dcEst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcAcc    <= '0;
      envOut   <= '0;
      audioOut <= '0;
      angleOut <= '0;
    end else begin
      envOut   <= envNext;
      audioOut <= audioWide[OUT_W-1:0];
      angleOut <= zfFin ? '0 : zFin;
      if (strb.commit) dcAcc <= dcAcc + audioWide;
    end
  end

  // R4: folded vectors keep x non-negative through every step
  a_r4_x_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    !xFin[XY_W-1]);

  // R4: after the last step y has been driven close to zero
  a_r4_y_converged: assert property (@(posedge clk) disable iff (!rstN)
    (yFin > -XY_W'(128)) && (yFin < XY_W'(128)));

  // R7: a zero vector stays zero through the first rotation
  a_r7_zero_stays_zero: assert property (@(posedge clk) disable iff (!rstN)
    foldZero |=> (stg[0].x == '0) && (stg[0].y == '0));

  // R8: filter state frozen on cycles that carry no result
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dcAcc));

  // R9: audio never reaches the most negative code
  a_r9_audio_range: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit) |-> (audioOut != {1'b1, {(OUT_W-1){1'b0}}}));

  // R9: envelope never negative
  a_r9_env_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    !envOut[OUT_W-1]);

endmodule

// File: rtl/envelopeVectorDetector.sv
module envelopeVectorDetector
  import envDetPkg::*;
#(
  parameter int IN_W     = 16,
  parameter int XY_W     = 18,
  parameter int ITER     = 16,
  parameter int OUT_W    = 16,
  parameter int HP_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [IN_W-1:0]  iIn,
  input  logic [IN_W-1:0]  qIn,
  output logic             validOut,
  output logic [OUT_W-1:0] envOut,
  output logic [OUT_W-1:0] audioOut,
  output logic [ANG_W-1:0] angleOut
);

  localparam int LAT = ITER + 2;

  ctrlStrb_t strb;

  envDetCtrl #(.LAT(LAT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strb     (strb),
    .validOut (validOut)
  );

  envDetDatapath #(
    .IN_W     (IN_W),
    .XY_W     (XY_W),
    .ITER     (ITER),
    .OUT_W    (OUT_W),
    .HP_SHIFT (HP_SHIFT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .iIn      (iIn),
    .qIn      (qIn),
    .strb     (strb),
    .envOut   (envOut),
    .audioOut (audioOut),
    .angleOut (angleOut)
  );

endmodule

// File: tb/envelopeVectorDetector_tb_top.sv
module envelopeVectorDetector_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [15:0] iIn = '0;
  logic [15:0] qIn = '0;
  logic        validOut;
  logic [15:0] envOut, audioOut, angleOut;

  always #2 clk = ~clk;   // 250 MHz

  envelopeVectorDetector dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .iIn(iIn), .qIn(qIn),
    .validOut(validOut), .envOut(envOut), .audioOut(audioOut), .angleOut(angleOut)
  );

  typedef struct { bit v; int i; int q; } smp_t;
  smp_t mq[$];
  int compared = 0;
  int mismatched = 0;
  int accModel = 0;
  bit done = 1'b0;
  int atanTab[16] = '{8192,4836,2555,1297,651,326,163,81,41,20,10,5,3,1,1,0};

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference for one sample (R3..R7)
  task automatic refModel(input int i, input int q, output int env,
                          output int ang, output bit sat);
    int x, y, z, xn, yn;
    x = i; y = q; z = 0;
    if (i < 0) begin x = -i; y = -q; z = 32768; end
    for (int k = 0; k < 16; k++) begin
      if (y < 0) begin
        xn = x - (y >>> k); yn = y + (x >>> k); z = z - atanTab[k];
      end else begin
        xn = x + (y >>> k); yn = y - (x >>> k); z = z + atanTab[k];
      end
      x = xn; y = yn;
    end
    env = (x * 311) >>> 9;
    sat = (env > 32767);
    if (sat) env = 32767;
    ang = (i == 0 && q == 0) ? 0 : (z & 65535);
  endtask

  // Input delay line of the model
  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
    end else begin
      mq.push_back('{validIn, int'($signed(iIn)), int'($signed(qIn))});
      if (mq.size() > 18) void'(mq.pop_front());
    end
  end

  // Compare on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit ev;
      ev = (mq.size() == 18) ? mq[0].v : 1'b0;
      check(validOut == ev, "R1", "validOut", int'(validOut), int'(ev));
      if (ev && validOut) begin
        int e, a, au;
        bit sat, zero;
        string tagA, tagE;
        refModel(mq[0].i, mq[0].q, e, a, sat);
        zero = (mq[0].i == 0 && mq[0].q == 0);
        tagA = zero ? "R7" : ((mq[0].i < 0) ? "R3" : "R5");
        tagE = zero ? "R7" : (sat ? "R6" : "R4");
        au = e - (accModel >>> 6);
        check(int'(envOut) == e, tagE, "envOut", int'(envOut), e);
        check(int'(angleOut) == a, tagA, "angleOut", int'(angleOut), a);
        check(int'($signed(audioOut)) == au, "R8", "audioOut",
              int'($signed(audioOut)), au);
        check(audioOut != 16'h8000 && !envOut[15], "R9", "range",
              int'($signed(audioOut)), au);
        accModel = accModel + au;
      end
    end
  end

  task automatic drive(input bit v, input int i, input int q);
    validIn = v;
    iIn = 16'(i);
    qIn = 16'(q);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check(validOut == 1'b0, "R2", "validOut in reset", int'(validOut), 0);
    check(envOut == '0, "R2", "envOut in reset", int'(envOut), 0);
    check(audioOut == '0, "R2", "audioOut in reset", int'(audioOut), 0);
    check(angleOut == '0, "R2", "angleOut in reset", int'(angleOut), 0);
    rstN = 1'b1;
    drive(0, 0, 0);

    // axes, zero vectors and quadrants (R3, R5, R7)
    drive(1, 1000, 0);    drive(1, 0, 1000);   drive(1, -1000, 0);
    drive(1, 0, -1000);   drive(1, 0, 0);      drive(1, -700, 700);
    drive(1, 0, 0);       drive(1, -700, -700); drive(1, 700, -700);
    drive(1, 5, 3);       drive(1, -1, 0);     drive(1, 0, 0);

    // full-scale corners back to back: clipping with filter update (R6, R8)
    drive(1, -32768, -32768); drive(1, 32767, 32767);
    drive(1, -32768, 32767);  drive(1, 32767, -32768);
    drive(1, -32768, 0);      drive(1, 0, -32768);
    drive(0, 0, 0);           drive(1, -32768, -32768);

    // amplitude-modulated tone with gaps (R1, R8)
    for (int n = 0; n < 240; n++) begin
      real amp, ph;
      amp = 9000.0 * (1.0 + 0.8 * $sin(6.2831853 * n / 40.0));
      ph  = 6.2831853 * 0.07 * n;
      drive((n % 5) != 3, $rtoi(amp * $cos(ph)), $rtoi(amp * $sin(ph)));
    end

    // random traffic with zero vectors and corners sprinkled in
    for (int n = 0; n < 400; n++) begin
      int sel, ri, rq;
      sel = $urandom_range(0, 15);
      ri = int'($signed(16'($urandom())));
      rq = int'($signed(16'($urandom())));
      if (sel == 0) begin ri = 0; rq = 0; end
      if (sel == 1) begin ri = -32768; rq = -32768; end
      drive($urandom_range(0, 3) != 0, ri, rq);
    end

    repeat (25) drive(0, 0, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule